// File: doc/BRIEF.md
# Embedded-Sync YCbCr 4:2:2 Byte Stream Decoder

This block takes an 8-bit multiplexed 4:2:2 YCbCr stream, one byte per qualified clock, and recovers the timing carried inside the stream itself. A timing reference code is four bytes long: 0xFF, 0x00, 0x00, then a status byte. The status byte gives the field, vertical-blanking and horizontal-reference flags. The first 0xFF of a code always falls in the byte slot where a Cb sample would sit. A start-of-active-video code therefore also fixes the byte phase, and the next byte is taken as Cb.

Inside active video the bytes repeat as Cb, Y, Cr, Y. The block splits them into registered luma and chroma samples and raises a pixel strobe once per luma byte. Each luma sample is presented with the complete Cb/Cr pair it shares with its neighbour. Downstream logic uses the flags and the start-of-active-video pulse to rebuild line and frame timing.

Top module: `ycc_sync_decoder`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, every output is zero.
- R2: A code is the byte run 0xFF, 0x00, 0x00 followed by a status byte, all with `byte_en` high. On the cycle after the status byte, `f_flag`, `v_flag` and `h_flag` take status bits 6, 5 and 4. They keep those values until the next complete code.
- R3: Status bits 7 and 3..0 have no effect on any output. A status byte equal to 0xFF is decoded as status and does not start a new code.
- R4: A broken preamble, such as 0xFF 0x00 then a non-zero byte, is discarded. If the breaking byte is 0xFF, it counts as the first byte of a new code.
- R5: `sav_pulse` is high for exactly one cycle, on the cycle after the status byte of a code whose bit 4 is 0.
- R6: After a start-of-active-video code, data bytes are taken in the order Cb, Y, Cr, Y. On the cycle after a Cr byte, `pix_valid` pulses with the first Y and the new Cb/Cr pair. On the cycle after the second Y, it pulses with that Y and the same pair.
- R7: `pix_valid` stays low from reset until the first start-of-active-video code. A data byte of 0xFF, or any code with bit 4 set, ends active video, and no pixel is produced until the next start-of-active-video code.
- R8: Clocks with `byte_en` low change no state and produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_en | input | 1 | Qualifies `din` on this clock |
| din | input | 8 | Stream byte |
| y_out | output | 8 | Luma sample |
| cb_out | output | 8 | Blue-difference sample of the current pair |
| cr_out | output | 8 | Red-difference sample of the current pair |
| pix_valid | output | 1 | One-cycle strobe per luma sample |
| f_flag | output | 1 | Field flag from the last status byte |
| v_flag | output | 1 | Vertical-blanking flag from the last status byte |
| h_flag | output | 1 | 1 after an end-of-active code, 0 after a start-of-active code |
| sav_pulse | output | 1 | One-cycle pulse after a start-of-active-video status byte |

## Verification
Code detection and pixel demultiplexing can both claim the same byte. The sharpest cases are a status byte of 0xFF, which must be decoded and must not restart the preamble, and a 0xFF on a luma slot inside active video, which must end the line and not produce a pixel. The bench drives both cases, along with a broken preamble whose breaking byte opens a real code. A behavioural model compares every output on every clock, so a byte taken by the wrong function shows up as a flag, strobe or sample mismatch in the cycle it occurs.

// File: rtl/ycc_pkg.sv
package ycc_pkg;
  localparam int unsigned BYTE_W = 8;
  // status-byte bit positions decoded downstream
  localparam int unsigned FLD_BIT = 6;
  localparam int unsigned VBL_BIT = 5;
  localparam int unsigned HRF_BIT = 4;
  // preamble marker bytes
  localparam logic [BYTE_W-1:0] MARK_HI = '1;
  localparam logic [BYTE_W-1:0] MARK_LO = '0;

  typedef enum logic [1:0] {
    SL_CB  = 2'd0,
    SL_Y0  = 2'd1,
    SL_CR  = 2'd2,
    SL_Y1  = 2'd3
  } slot_t;

  typedef struct packed {
    logic fld;
    logic vbl;
    logic hrf;
  } tflags_t;
endpackage

// File: rtl/ycc_code_detect.sv
module ycc_code_detect
  import ycc_pkg::*;
#(
  parameter int unsigned DW = BYTE_W,
  parameter int unsigned PRE_LEN = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [DW-1:0] din,
  output logic          hit
);
  localparam int unsigned CW = $clog2(PRE_LEN + 1);
  localparam logic [CW-1:0] FULL = CW'(PRE_LEN);

  logic [CW-1:0] matched;

  assign hit = en && (matched == FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      matched <= '0;
    end else if (en) begin
      if (matched == FULL)
        matched <= '0;                         // status byte consumed
      else if (din == DW'(MARK_HI))
        matched <= CW'(1);                     // any 0xFF restarts
      else if (din == DW'(MARK_LO) && matched != '0)
        matched <= matched + CW'(1);
      else
        matched <= '0;
    end
  end
endmodule

// File: rtl/ycc_flag_regs.sv
module ycc_flag_regs
  import ycc_pkg::*;
#(
  parameter int unsigned DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit,
  input  logic [DW-1:0] status,
  output tflags_t       flags
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
    end else if (hit) begin
      flags.fld <= status[FLD_BIT];
      flags.vbl <= status[VBL_BIT];
      flags.hrf <= status[HRF_BIT];
    end
  end
endmodule

// File: rtl/ycc_pixel_demux.sv
module ycc_pixel_demux
  import ycc_pkg::*;
#(
  parameter int unsigned DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [DW-1:0] din,
  input  logic          hit,
  output logic [DW-1:0] y_q,
  output logic [DW-1:0] cb_q,
  output logic [DW-1:0] cr_q,
  output logic          pix_q,
  output logic          sav_q
);
  slot_t         slot;
  logic          active;
  logic [DW-1:0] cb_hold;
  logic [DW-1:0] y_hold;
  logic          is_sav;

  assign is_sav = hit && !din[HRF_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      slot    <= SL_CB;
      active  <= 1'b0;
      cb_hold <= '0;
      y_hold  <= '0;
      y_q     <= '0;
      cb_q    <= '0;
      cr_q    <= '0;
      pix_q   <= 1'b0;
      sav_q   <= 1'b0;
    end else begin
      pix_q <= 1'b0;
      sav_q <= 1'b0;
      if (en) begin
        if (hit) begin
          active <= is_sav;
          slot   <= SL_CB;
          sav_q  <= is_sav;
        end else if (din == DW'(MARK_HI)) begin
          active <= 1'b0;
        end else if (active) begin
          slot <= slot_t'(slot + 2'd1);
          unique case (slot)
            SL_CB: cb_hold <= din;
            SL_Y0: y_hold  <= din;
            SL_CR: begin
              cb_q  <= cb_hold;
              cr_q  <= din;
              y_q   <= y_hold;
              pix_q <= 1'b1;
            end
            SL_Y1: begin
              y_q   <= din;
              pix_q <= 1'b1;
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/ycc_sync_decoder.sv
module ycc_sync_decoder
  import ycc_pkg::*;
#(
  parameter int unsigned DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          byte_en,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] y_out,
  output logic [DW-1:0] cb_out,
  output logic [DW-1:0] cr_out,
  output logic          pix_valid,
  output logic          f_flag,
  output logic          v_flag,
  output logic          h_flag,
  output logic          sav_pulse
);
  logic    code_hit;
  tflags_t flags;

  ycc_code_detect #(.DW(DW)) i_detect (
    .clk (clk), .rst (rst), .en (byte_en), .din (din), .hit (code_hit)
  );

  ycc_flag_regs #(.DW(DW)) i_flags (
    .clk (clk), .rst (rst), .hit (code_hit), .status (din), .flags (flags)
  );

  ycc_pixel_demux #(.DW(DW)) i_demux (
    .clk (clk), .rst (rst), .en (byte_en), .din (din), .hit (code_hit),
    .y_q (y_out), .cb_q (cb_out), .cr_q (cr_out),
    .pix_q (pix_valid), .sav_q (sav_pulse)
  );

  assign f_flag = flags.fld;
  assign v_flag = flags.vbl;
  assign h_flag = flags.hrf;

  // checker state: has a start-of-active code been seen since reset
  logic sav_seen;
  always_ff @(posedge clk) begin
    if (rst) sav_seen <= 1'b0;
    else if (sav_pulse) sav_seen <= 1'b1;
  end

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(code_hit) |-> $stable({f_flag, v_flag, h_flag})); // R2
  AST_SAV_AFTER_CODE: assert property (@(posedge clk) disable iff (rst)
    sav_pulse |-> ($past(code_hit) && !h_flag)); // R5
  AST_PIX_SAV_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pix_valid, sav_pulse})); // R6
  AST_NO_PIX_BEFORE_SAV: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> sav_seen); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !$past(byte_en) |-> (!pix_valid && !sav_pulse)); // R8
endmodule

// File: tb/test_ycc_sync_decoder.sv
module test_ycc_sync_decoder;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       byte_en = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] y_out, cb_out, cr_out;
  logic       pix_valid, f_flag, v_flag, h_flag, sav_pulse;

  always #(CLK_PERIOD/2) clk = ~clk;

  ycc_sync_decoder i_ycc_sync_decoder (
    .clk(clk), .rst(rst), .byte_en(byte_en), .din(din),
    .y_out(y_out), .cb_out(cb_out), .cr_out(cr_out), .pix_valid(pix_valid),
    .f_flag(f_flag), .v_flag(v_flag), .h_flag(h_flag), .sav_pulse(sav_pulse)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done  = 0;
  string tag   = "R1";

  // behavioural reference
  int  hist[$];
  bit  m_act = 0;
  int  m_k = 0;
  int  m_cbt = 0, m_y0 = 0;
  int  m_y = 0, m_cb = 0, m_cr = 0;
  bit  m_pix = 0, m_sav = 0, m_f = 0, m_v = 0, m_h = 0;

  task automatic check(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check("y_out", y_out, m_y);
    check("cb_out", cb_out, m_cb);
    check("cr_out", cr_out, m_cr);
    check("pix_valid", pix_valid, m_pix);
    check("sav_pulse", sav_pulse, m_sav);
    check("flags", {f_flag, v_flag, h_flag}, {m_f, m_v, m_h});
  endtask

  task automatic model_step(int b, bit e);
    m_pix = 0;
    m_sav = 0;
    if (!e) return;
    if (hist.size() == 3 && hist[0] == 255 && hist[1] == 0 && hist[2] == 0) begin
      m_f = b[6]; m_v = b[5]; m_h = b[4];
      hist.delete();
      if (b[4] == 0) begin m_act = 1; m_k = 0; m_sav = 1; end
      else m_act = 0;
    end else begin
      hist.push_back(b);
      if (hist.size() > 3) void'(hist.pop_front());
      if (b == 255) m_act = 0;
      else if (m_act) begin
        case (m_k % 4)
          0: m_cbt = b;
          1: m_y0 = b;
          2: begin m_cb = m_cbt; m_cr = b; m_y = m_y0; m_pix = 1; end
          default: begin m_y = b; m_pix = 1; end
        endcase
        m_k++;
      end
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic send(int b, bit e = 1);
    din = b[7:0];
    byte_en = e;
    @(posedge clk);
    model_step(b, e);
    @(negedge clk);
    compare_all();
  endtask

  task automatic code(int s);
    send(8'hFF); send(8'h00); send(8'h00); send(s);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    compare_all();                       // R1 during reset
    rst = 1'b0;
    send(8'h00, 0);                      // R1 first cycle after reset

    tag = "R7";                          // R7 no pixels before first SAV
    send(8'h10); send(8'h80); send(8'h20); send(8'h90); send(8'h30);

    tag = "R5";                          // R5/R2 SAV, bit7 set, R3 junk low bits
    code(8'h8A);
    tag = "R6";                          // R6 Cb Y Cr Y ordering
    send(8'h11); send(8'h22); send(8'h33); send(8'h44);
    send(8'h55); send(8'h66);
    tag = "R8";                          // R8 idle gap mid-pixel
    send(8'hA5, 0); send(8'h5A, 0); send(8'hFF, 0);
    send(8'h77); send(8'h88);
    tag = "R2";                          // R2 EAV, R3 junk in low bits
    code(8'h9D);
    tag = "R7";                          // R7 blanking data yields nothing
    send(8'h10); send(8'h80); send(8'h10); send(8'h80);

    tag = "R4";                          // R4 broken preamble, then restart
    send(8'hFF); send(8'h00); send(8'h12);
    send(8'hFF); send(8'h00); send(8'hFF); send(8'h00); send(8'h00); send(8'hEF);
    tag = "R6";
    send(8'hC1); send(8'hC2); send(8'hC3); send(8'hC4);
    tag = "R7";                          // R7 0xFF on a luma slot ends line
    send(8'hD1); send(8'hFF); send(8'hD3); send(8'hD4); send(8'hD5); send(8'hD6);

    tag = "R3";                          // R3 status 0xFF is status only
    code(8'hFF);
    send(8'h00); send(8'h00); send(8'h05); send(8'h06);
    tag = "R2";                          // R2 flags return to zero
    code(8'h00);
    tag = "R6";
    for (int i = 0; i < 8; i++) send(8'h40 + i);
    tag = "R4";                          // R4 FF 00 00 inside queue via FF FF
    send(8'hFF); send(8'hFF); send(8'h00); send(8'h00); send(8'h4F);
    send(8'h21); send(8'h22); send(8'h23); send(8'h24);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule